// File: doc/BRIEF.md
# Bit-to-Priority-Level Interrupt Mapper

This block is a single-CPU interrupt controller that spreads eight level-sensitive device request lines over a sixteen-line processor priority level vector. It does not priority-encode the inputs. Each input has a fixed destination level, and the destinations are sparse. Two inputs have level 0 as their destination, so they can never raise anything.

A single byte-wide control register sits behind a minimal byte-access register port. The port has a select, a write strobe, a read strobe and 8-bit data in each direction. Bit 0 of the register is a global delivery enable. Bit 6 is always stored as zero. The priority-level outputs are registered and follow a change on any input, or a register write, one clock later.

Top module: `pil_mapper`

## Requirements
- R1: After reset the control register holds 0x01, every priority-level output is low and the read data port drives 0x00.
- R2: Input index 1, 2, 3, 4, 5 and 7 drives priority-level line 1, 4, 6, 8, 10 and 14 respectively, while bit 0 of the control register is 1.
- R3: Inputs 0 and 6 have no effect on any output, whatever their value.
- R4: Inputs are level-sensitive. A line falls one clock after every input mapped to it goes low.
- R5: Several simultaneously high inputs assert all of their lines together. The output vector is the OR of the individual contributions.
- R6: A write takes effect only when the select and the write strobe are both high. The value stored is the write data ANDed with 0xBF, so bit 6 always reads back as 0.
- R7: When select and the read strobe are high in a cycle, read data in the next cycle is the register value held before that edge. In any other cycle the read data is 0x00.
- R8: While bit 0 of the control register is 0, all outputs are held low. The inputs are still tracked, so setting bit 0 back to 1 shows the current inputs one clock after the write.
- R9: Line 0 is never asserted. Lines 2, 3, 5, 7, 9, 11, 12, 13 and 15 are never asserted either.
- R10: The outputs change exactly one clock edge after the input change or register write that causes the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Level-sensitive device requests, synchronous to clk |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle after the read strobe |
| pil_out | output | 16 | Priority-level lines to the processor |

## Verification
A wrong stored control byte shows on the read port in the cycle after the next read strobe. If its enable bit is wrong, the outputs go wrong one edge after any input activity. A wrong routing entry shows as a wrong or missing output line one edge after the affected input rises. Every single-input pattern is therefore applied, and several multi-input patterns as well. An output that changes too early shows up as a mismatch against the value sampled before the edge. Dead inputs and the stored form of bit 6 are observed through the outputs and through readback, right after the stimulus.

// File: rtl/pil_map_pkg.sv
package pil_map_pkg;
    localparam int NUM_IRQ = 8;
    localparam int NUM_PIL = 16;
    localparam int LVL_W   = $clog2(NUM_PIL);
    localparam int REG_W   = 8;
    localparam int EN_BIT  = 0;
    localparam logic [REG_W-1:0] WR_KEEP   = 8'hBF;
    localparam logic [REG_W-1:0] CTRL_INIT = 8'h01;

    // destination level per input; 0 means the input is unused
    function automatic logic [LVL_W-1:0] level_of(input int idx);
        logic [LVL_W-1:0] lvl;
        unique case (idx)
            1:       lvl = 4'd1;
            2:       lvl = 4'd4;
            3:       lvl = 4'd6;
            4:       lvl = 4'd8;
            5:       lvl = 4'd10;
            7:       lvl = 4'd14;
            default: lvl = 4'd0;
        endcase
        return lvl;
    endfunction

    // set of lines that any live input can reach
    function automatic logic [NUM_PIL-1:0] reachable_lines();
        logic [NUM_PIL-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (level_of(i) != '0) m[level_of(i)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/pil_ctrl_reg.sv
module pil_ctrl_reg
    import pil_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic             rd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             en_now,
    output logic             en_next
);
    logic [REG_W-1:0] ctrl_q;
    logic             wr_hit;
    logic             rd_hit;

    assign wr_hit = sel && wr;
    assign rd_hit = sel && rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
        end else if (wr_hit) begin
            ctrl_q <= wdata & WR_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_hit ? ctrl_q : '0;
        end
    end

    assign en_now  = ctrl_q[EN_BIT];
    assign en_next = wr_hit ? wdata[EN_BIT] : ctrl_q[EN_BIT];
endmodule

// File: rtl/pil_router.sv
module pil_router
    import pil_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               en_next,
    output logic [NUM_PIL-1:0] pil_q
);
    localparam logic [NUM_PIL-1:0] ONE = {{(NUM_PIL-1){1'b0}}, 1'b1};

    logic [NUM_PIL-1:0] contrib [NUM_IRQ];
    logic [NUM_PIL-1:0] merged;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_in
        localparam logic [LVL_W-1:0] LVL = level_of(g);
        if (LVL != '0) begin : g_live
            assign contrib[g] = irq_in[g] ? (ONE << LVL) : '0;
        end else begin : g_dead
            assign contrib[g] = '0;
        end
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            merged = merged | contrib[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pil_q <= '0;
        end else begin
            pil_q <= en_next ? merged : '0;
        end
    end
endmodule

// File: rtl/pil_mapper.sv
module pil_mapper
    import pil_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [NUM_PIL-1:0] pil_out
);
    localparam logic [NUM_PIL-1:0] REACH = reachable_lines();

    logic en_now;
    logic en_next;

    pil_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (reg_sel),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .en_now  (en_now),
        .en_next (en_next)
    );

    pil_router u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .en_next (en_next),
        .pil_q   (pil_out)
    );

    AST_RD_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6] == 1'b0);                                           // R6
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_rd) |=> reg_rdata == '0);                       // R7
    AST_ONLY_REACHABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pil_out & ~REACH) == '0);                                       // R9
    AST_DISABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && !reg_wdata[EN_BIT]) |=> pil_out == '0);    // R8
    AST_TOP_INPUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in[7] && en_now && !(reg_sel && reg_wr)) |=> pil_out[14]);  // R10
    AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_in[1] |=> !pil_out[1]);                                     // R4
endmodule

// File: tb/pil_mapper_bench.sv
module pil_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_in = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pil_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pil_mapper u_pil_mapper (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pil_out(pil_out)
    );

    // {inputs, expected lines} with delivery enabled (R2, R3, R5)
    localparam logic [23:0] VEC [10] = '{
        24'h02_0002, 24'h04_0010, 24'h08_0040, 24'h10_0100, 24'h20_0400,
        24'h80_4000, 24'h41_0000, 24'hFF_4552, 24'hA6_4412, 24'h00_0000
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
        step();
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_read(output logic [7:0] v);
        reg_sel = 1'b1; reg_rd = 1'b1;
        step();
        v = reg_rdata;
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pil after reset", pil_out, 16'h0000);
        check("R1 rdata after reset", {8'h00, reg_rdata}, 16'h0000);
        do_read(rv);
        check("R1 ctrl reset value", {8'h00, rv}, 16'h0001);
        step();
        check("R7 rdata idle", {8'h00, reg_rdata}, 16'h0000);

        // vector walk: R2 R3 R5, with R10 no-early-change check
        for (int i = 0; i < 10; i++) begin
            logic [15:0] prev;
            prev = pil_out;
            irq_in = VEC[i][23:16];
            #1;
            check("R10 before edge", pil_out, prev);
            step();
            check("R2 R3 R5 vector", pil_out, VEC[i][15:0]);
        end

        // R4 level drop
        irq_in = 8'h80; step();
        irq_in = 8'h00; step();
        check("R4 line falls", pil_out, 16'h0000);

        // R9 dead inputs alone, line 0 stays low
        irq_in = 8'h41; step();
        check("R9 line0 low", {15'h0, pil_out[0]}, 16'h0000);
        check("R3 dead inputs", pil_out, 16'h0000);

        // R6 write mask
        irq_in = 8'h00;
        do_write(8'hFF);
        do_read(rv);
        check("R6 bit6 masked", {8'h00, rv}, 16'h00BF);
        do_write(8'h40);
        do_read(rv);
        check("R6 bit6 only", {8'h00, rv}, 16'h0000);

        // R8 disabled: outputs low, inputs tracked
        irq_in = 8'hFF; step();
        check("R8 disabled low", pil_out, 16'h0000);
        do_write(8'h01);
        check("R8 re-enable shows inputs", pil_out, 16'h4552);

        // R6 write without select ignored
        reg_wr = 1'b1; reg_wdata = 8'h00; step();
        reg_wr = 1'b0;
        check("R6 unselected write", pil_out, 16'h4552);
        do_read(rv);
        check("R6 value kept", {8'h00, rv}, 16'h0001);

        // R7 read concurrent with write returns old value
        reg_sel = 1'b1; reg_rd = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h21;
        step();
        reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        check("R7 old value", {8'h00, reg_rdata}, 16'h0001);
        do_read(rv);
        check("R7 new value", {8'h00, rv}, 16'h0021);

        // R1 reset mid-run with inputs high
        rst_n = 1'b0; step(); rst_n = 1'b1;
        check("R1 pil cleared", pil_out, 16'h0000);
        step();
        check("R1 enabled after reset", pil_out, 16'h4552);
        do_read(rv);
        check("R1 ctrl restored", {8'h00, rv}, 16'h0001);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule